// File: doc/BRIEF.md
# Recorded-List Prefetch Engine

This block serves one hardware thread and works in two ways. While recording, it takes the L1 miss line addresses of a repeating code region and sends them out as a stream to a list writer, which stores them in memory. While playing back, it reads an earlier list as a stream into an eight-entry lookahead window. It holds the core stalled until that window is loaded. It then compares each new miss with the window and asks for prefetches of the list addresses that follow a match. Playback and recording can run together, so a fresh list can replace the old one on the same pass.

A miss is compared with the oldest window entry and the seven entries behind it. The lowest matching position wins, and every entry up to and including that one is dropped. When some recorded misses do not come back, the engine stays in step with the program because it skips over them. Software can pause and resume the engine. It can also copy the whole engine state into a single shadow copy and later load that copy back, for example around a subroutine call.

There are three streams: list read, list write and prefetch requests. All three use valid/ready handshakes. The list-write beat is registered. Once it is offered it stays unchanged until it is taken. The list-read side takes a beat only when `lr_ready` is high. A prefetch offer is built from the engine state. Until it is taken, a match, a pause or a command may withdraw it or change it. The miss input has no ready signal, and the engine looks at every miss.

Top module: `lpf_list_engine`

## Requirements
- R1: After reset, `lr_ready`, `pf_valid`, `lw_valid` and `core_stall` are all low.
- R2: While recording and not paused, a miss with `miss_rec_ok` high is offered on the list-write stream one cycle later, carrying its address. A miss with `miss_rec_ok` low is not written.
- R3: A list-write beat that is offered keeps its address and `lw_last` until `lw_ready` takes it. A miss that arrives while a beat is waiting and is not taken in that cycle is not recorded.
- R4: The beat that brings the recorded count to `cfg_max_len` has `lw_last` set, and recording then stops. A `cfg_max_len` of 0 behaves like 1.
- R5: A start command with `cmd_start_play` high raises `core_stall` one cycle later. The stall drops in the cycle after the window holds eight entries or the list read has ended.
- R6: `lr_ready` is high only while playing, not paused, with the window below eight entries and the read not ended. The read ends after a beat with `lr_last` set, or after the `cfg_max_len`-th beat.
- R7: A miss during playback is compared with the valid window entries, oldest first (position 0). When the lowest match is at position k, positions 0 to k are removed. A miss that matches nothing leaves the window and the prefetch progress unchanged.
- R8: After the first match, `pf_valid` offers window entries in order, oldest first, until `cfg_depth` entries of the remaining window have been requested. A match gives back the requests that covered the entries it removed.
- R9: With both `cmd_start_play` and `cmd_start_rec` set, playback matching and list writing run in the same cycles from the same misses.
- R10: From the cycle after `cmd_pause`, `lr_ready` and `pf_valid` are low, and misses are neither matched nor recorded, until `cmd_resume`. When both commands arrive together, pause wins.
- R11: `cmd_save` copies the complete engine state (window, counts, mode, pause and stall flags) into the shadow copy. `cmd_restore` brings that copy back in the next cycle. The pending list-write beat is not affected.
- R12: Commands rank restore, then start, then stop, above normal work. In a cycle that carries one of them, no miss is matched or recorded and no list-read or prefetch handshake counts.
- R13: After `cmd_stop`, `lr_ready`, `pf_valid` and `core_stall` are low and the window is empty. A pending write beat is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse |
| cmd_start_play | input | 1 | With start: enable playback |
| cmd_start_rec | input | 1 | With start: enable recording |
| cmd_stop | input | 1 | Stop pulse |
| cmd_pause | input | 1 | Pause pulse |
| cmd_resume | input | 1 | Resume pulse |
| cmd_save | input | 1 | Copy state to shadow |
| cmd_restore | input | 1 | Load state from shadow |
| cfg_depth | input | CW | Prefetch depth, 0 to WIN |
| cfg_max_len | input | LW | Maximum list length |
| miss_valid | input | 1 | Miss present |
| miss_addr | input | AW | Miss line address |
| miss_rec_ok | input | 1 | Miss may be recorded |
| lr_valid | input | 1 | List-read beat valid |
| lr_ready | output | 1 | List-read beat accepted |
| lr_addr | input | AW | List-read address |
| lr_last | input | 1 | List-read end marker |
| lw_valid | output | 1 | List-write beat valid |
| lw_ready | input | 1 | List-write beat accepted |
| lw_addr | output | AW | List-write address |
| lw_last | output | 1 | Final beat of recorded list |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_addr | output | AW | Prefetch line address |
| core_stall | output | 1 | Hold the core |

## Verification
If the window shifts by the wrong amount, or the prefetch pointer slips, the wrong `pf_addr` shows up at the next offer. That is usually the cycle right after the match that caused the error. A wrong fill count or a missed end marker shows up at `lr_ready` or `core_stall` within one cycle. A shadow copy that missed some field shows up as soon as playback moves on after a restore. The bench runs a behavioural model next to the design and compares every output in every cycle, so a difference is caught in the cycle it first reaches a port.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  typedef enum logic [1:0] {
    CMD_RUN,
    CMD_RESTORE,
    CMD_START,
    CMD_STOP
  } lpf_cmd_e;

  // restore ranks above start, start above stop
  function automatic lpf_cmd_e lpf_decode(input logic restore, input logic start,
                                          input logic stop);
    if (restore) return CMD_RESTORE;
    if (start) return CMD_START;
    if (stop) return CMD_STOP;
    return CMD_RUN;
  endfunction

endpackage

// File: rtl/lpf_window.sv
module lpf_window #(
  parameter int AW = 32,
  parameter int WIN = 8,
  parameter int CW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    ld,
  input  logic [WIN-1:0][AW-1:0]  ld_ent,
  input  logic [CW-1:0]           ld_cnt,
  input  logic                    pop_en,
  input  logic [CW-1:0]           pop_n,
  input  logic                    push,
  input  logic [AW-1:0]           push_addr,
  output logic [WIN-1:0][AW-1:0]  ent,
  output logic [CW-1:0]           cnt
);

  logic [WIN-1:0][AW-1:0] ent_q, nxt;
  logic [CW-1:0]          cnt_q, cnt_nx;

  always_comb begin
    int pn;
    int keep;
    pn = pop_en ? int'(pop_n) : 0;
    for (int i = 0; i < WIN; i++) begin
      nxt[i] = '0;
      for (int j = 0; j < WIN; j++)
        if (j == i + pn) nxt[i] = ent_q[j];
    end
    keep = int'(cnt_q) - pn;
    if (push)
      for (int i = 0; i < WIN; i++)
        if (i == keep) nxt[i] = push_addr;
    cnt_nx = CW'(keep + (push ? 1 : 0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      ent_q <= ld_ent;
      cnt_q <= ld_cnt;
    end else if (clr) begin
      cnt_q <= '0;
    end else begin
      ent_q <= nxt;
      cnt_q <= cnt_nx;
    end
  end

  assign ent = ent_q;
  assign cnt = cnt_q;

endmodule

// File: rtl/lpf_match.sv
module lpf_match #(
  parameter int AW = 32,
  parameter int WIN = 8,
  parameter int CW = 4
) (
  input  logic [WIN-1:0][AW-1:0] ent,
  input  logic [CW-1:0]          cnt,
  input  logic [AW-1:0]          addr,
  output logic                   hit,
  output logic [CW-1:0]          idx
);

  logic [WIN-1:0] eq;

  for (genvar g = 0; g < WIN; g++) begin : g_cmp
    assign eq[g] = (CW'(g) < cnt) && (ent[g] == addr);
  end

  always_comb begin
    idx = '0;
    for (int i = WIN - 1; i >= 0; i--)
      if (eq[i]) idx = CW'(i);
  end

  assign hit = |eq;

endmodule

// File: rtl/lpf_recorder.sv
module lpf_recorder #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_rec,
  input  logic          stop,
  input  logic          ld,
  input  logic          ld_active,
  input  logic [LW-1:0] ld_cnt,
  input  logic          cap_en,
  input  logic [AW-1:0] cap_addr,
  input  logic [LW-1:0] max_len,
  input  logic          lw_ready,
  output logic          lw_valid,
  output logic [AW-1:0] lw_addr,
  output logic          lw_last,
  output logic          active,
  output logic [LW-1:0] cnt
);

  logic          act_q;
  logic [LW-1:0] cnt_q;
  logic          take, last_n;

  assign last_n = ({1'b0, cnt_q} + (LW+1)'(1)) >= {1'b0, max_len};
  assign take   = cap_en && act_q && (!lw_valid || lw_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lw_valid <= 1'b0;
      lw_addr  <= '0;
      lw_last  <= 1'b0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (take) begin
        lw_valid <= 1'b1;
        lw_addr  <= cap_addr;
        lw_last  <= last_n;
      end else if (lw_ready) begin
        lw_valid <= 1'b0;
      end
      if (ld) begin
        act_q <= ld_active;
        cnt_q <= ld_cnt;
      end else if (start) begin
        act_q <= start_rec;
        cnt_q <= '0;
      end else if (stop) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + LW'(1);
        if (last_n) act_q <= 1'b0;
      end
    end
  end

  assign active = act_q;
  assign cnt    = cnt_q;

endmodule

// File: rtl/lpf_list_engine.sv
module lpf_list_engine
  import lpf_pkg::*;
#(
  parameter int AW = 32,
  parameter int WIN = 8,
  parameter int LW = 16,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_start_play,
  input  logic          cmd_start_rec,
  input  logic          cmd_stop,
  input  logic          cmd_pause,
  input  logic          cmd_resume,
  input  logic          cmd_save,
  input  logic          cmd_restore,
  input  logic [CW-1:0] cfg_depth,
  input  logic [LW-1:0] cfg_max_len,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  input  logic          miss_rec_ok,
  input  logic          lr_valid,
  output logic          lr_ready,
  input  logic [AW-1:0] lr_addr,
  input  logic          lr_last,
  output logic          lw_valid,
  input  logic          lw_ready,
  output logic [AW-1:0] lw_addr,
  output logic          lw_last,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] pf_addr,
  output logic          core_stall
);

  lpf_cmd_e cmd;
  logic normal, run;

  // live state
  logic          play_q, paused_q, loading_q, armed_q, rdone_q;
  logic [CW-1:0] iss_q;
  logic [LW-1:0] rdcnt_q;
  // shadow copy
  logic                   sh_play, sh_paused, sh_loading, sh_armed, sh_rdone, sh_rec;
  logic [CW-1:0]          sh_iss, sh_cnt;
  logic [LW-1:0]          sh_rdcnt, sh_reccnt;
  logic [WIN-1:0][AW-1:0] sh_ent;

  logic [WIN-1:0][AW-1:0] went;
  logic [CW-1:0]          wcnt, wcnt_nx, m_idx, pop_n, iss_inc, iss_next;
  logic                   m_hit, do_match, hs_rd, hs_pf, rd_end, rec_act;
  logic [LW-1:0]          rec_cnt;

  assign cmd    = lpf_decode(cmd_restore, cmd_start, cmd_stop);
  assign normal = (cmd == CMD_RUN);
  assign run    = play_q && !paused_q;

  assign lr_ready   = run && !rdone_q && (wcnt < CW'(WIN));
  assign pf_valid   = run && armed_q && (iss_q < cfg_depth) && (iss_q < wcnt);
  assign core_stall = play_q && loading_q;

  always_comb begin
    pf_addr = '0;
    for (int i = 0; i < WIN; i++)
      if (iss_q == CW'(i)) pf_addr = went[i];
  end

  lpf_match #(.AW(AW), .WIN(WIN), .CW(CW)) u_match (
    .ent(went), .cnt(wcnt), .addr(miss_addr), .hit(m_hit), .idx(m_idx)
  );

  assign hs_rd    = normal && lr_valid && lr_ready;
  assign hs_pf    = normal && pf_valid && pf_ready;
  assign do_match = normal && run && miss_valid && m_hit;
  assign pop_n    = m_idx + CW'(1);
  assign iss_inc  = iss_q + CW'(hs_pf);
  assign iss_next = do_match ? ((iss_inc > pop_n) ? iss_inc - pop_n : '0) : iss_inc;
  assign rd_end   = hs_rd && (lr_last || (({1'b0, rdcnt_q} + (LW+1)'(1)) >= {1'b0, cfg_max_len}));
  assign wcnt_nx  = wcnt - (do_match ? pop_n : '0) + CW'(hs_rd);

  lpf_window #(.AW(AW), .WIN(WIN), .CW(CW)) u_window (
    .clk(clk), .rst_n(rst_n),
    .clr(cmd == CMD_START || cmd == CMD_STOP),
    .ld(cmd == CMD_RESTORE), .ld_ent(sh_ent), .ld_cnt(sh_cnt),
    .pop_en(do_match), .pop_n(pop_n),
    .push(hs_rd), .push_addr(lr_addr),
    .ent(went), .cnt(wcnt)
  );

  lpf_recorder #(.AW(AW), .LW(LW)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .start(cmd == CMD_START), .start_rec(cmd_start_rec),
    .stop(cmd == CMD_STOP),
    .ld(cmd == CMD_RESTORE), .ld_active(sh_rec), .ld_cnt(sh_reccnt),
    .cap_en(normal && !paused_q && miss_valid && miss_rec_ok),
    .cap_addr(miss_addr), .max_len(cfg_max_len),
    .lw_ready(lw_ready), .lw_valid(lw_valid), .lw_addr(lw_addr), .lw_last(lw_last),
    .active(rec_act), .cnt(rec_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play_q <= 1'b0; paused_q <= 1'b0; loading_q <= 1'b0;
      armed_q <= 1'b0; rdone_q <= 1'b0; iss_q <= '0; rdcnt_q <= '0;
    end else begin
      unique case (cmd)
        CMD_RESTORE: begin
          play_q <= sh_play; paused_q <= sh_paused; loading_q <= sh_loading;
          armed_q <= sh_armed; rdone_q <= sh_rdone; iss_q <= sh_iss; rdcnt_q <= sh_rdcnt;
        end
        CMD_START: begin
          play_q <= cmd_start_play; paused_q <= 1'b0; loading_q <= cmd_start_play;
          armed_q <= 1'b0; rdone_q <= 1'b0; iss_q <= '0; rdcnt_q <= '0;
        end
        CMD_STOP: begin
          play_q <= 1'b0; paused_q <= 1'b0; loading_q <= 1'b0;
          armed_q <= 1'b0; rdone_q <= 1'b0; iss_q <= '0; rdcnt_q <= '0;
        end
        default: begin
          if (cmd_pause) paused_q <= 1'b1;
          else if (cmd_resume) paused_q <= 1'b0;
          if (run) begin
            iss_q <= iss_next;
            if (do_match) armed_q <= 1'b1;
            if (hs_rd) rdcnt_q <= rdcnt_q + LW'(1);
            if (rd_end) rdone_q <= 1'b1;
            if (loading_q && (wcnt_nx == CW'(WIN) || rdone_q || rd_end)) loading_q <= 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_play <= 1'b0; sh_paused <= 1'b0; sh_loading <= 1'b0; sh_armed <= 1'b0;
      sh_rdone <= 1'b0; sh_rec <= 1'b0; sh_iss <= '0; sh_cnt <= '0;
      sh_rdcnt <= '0; sh_reccnt <= '0; sh_ent <= '0;
    end else if (cmd_save) begin
      sh_play <= play_q; sh_paused <= paused_q; sh_loading <= loading_q;
      sh_armed <= armed_q; sh_rdone <= rdone_q; sh_rec <= rec_act;
      sh_iss <= iss_q; sh_cnt <= wcnt; sh_rdcnt <= rdcnt_q;
      sh_reccnt <= rec_cnt; sh_ent <= went;
    end
  end

endmodule

// File: rtl/lpf_checker.sv
module lpf_checker #(
  parameter int WIN = 8,
  parameter int CW = 4,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          cmd_start_play,
  input logic          cmd_stop,
  input logic          cmd_pause,
  input logic          cmd_restore,
  input logic          lr_valid,
  input logic          lr_ready,
  input logic          lr_last,
  input logic          lw_valid,
  input logic          lw_ready,
  input logic [AW-1:0] lw_addr,
  input logic          lw_last,
  input logic          pf_valid,
  input logic          core_stall,
  input logic [CW-1:0] win_cnt
);

  a_r3_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_valid && !lw_ready) |=> (lw_valid && $stable(lw_addr) && $stable(lw_last)));

  a_r6_read_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_valid && lr_ready && lr_last && !cmd_restore && !cmd_start && !cmd_stop) |=> !lr_ready);

  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CW'(WIN));

  a_r10_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pause && !cmd_restore && !cmd_start && !cmd_stop) |=> (!lr_ready && !pf_valid));

  a_r13_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cmd_restore && !cmd_start) |=> (!lr_ready && !pf_valid && !core_stall && win_cnt == '0));

  a_r5_stall_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_start_play && !cmd_restore) |=> core_stall);

endmodule

bind lpf_list_engine lpf_checker #(.WIN(WIN), .CW(CW), .AW(AW)) u_lpf_checker (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_start_play(cmd_start_play),
  .cmd_stop(cmd_stop), .cmd_pause(cmd_pause), .cmd_restore(cmd_restore),
  .lr_valid(lr_valid), .lr_ready(lr_ready), .lr_last(lr_last),
  .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_addr(lw_addr), .lw_last(lw_last),
  .pf_valid(pf_valid), .core_stall(core_stall), .win_cnt(wcnt)
);

// File: tb/test_lpf_list_engine.sv
module test_lpf_list_engine;
  localparam int AW = 32, WIN = 8, LW = 16, CW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_start, cmd_start_play, cmd_start_rec, cmd_stop, cmd_pause;
  logic cmd_resume, cmd_save, cmd_restore;
  logic [CW-1:0] cfg_depth;
  logic [LW-1:0] cfg_max_len;
  logic miss_valid, miss_rec_ok, lr_valid, lr_ready, lr_last;
  logic lw_valid, lw_ready, lw_last, pf_valid, pf_ready, core_stall;
  logic [AW-1:0] miss_addr, lr_addr, lw_addr, pf_addr;

  lpf_list_engine #(.AW(AW), .WIN(WIN), .LW(LW)) i_lpf_list_engine (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_start_play(cmd_start_play),
    .cmd_start_rec(cmd_start_rec), .cmd_stop(cmd_stop), .cmd_pause(cmd_pause),
    .cmd_resume(cmd_resume), .cmd_save(cmd_save), .cmd_restore(cmd_restore),
    .cfg_depth(cfg_depth), .cfg_max_len(cfg_max_len),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_rec_ok(miss_rec_ok),
    .lr_valid(lr_valid), .lr_ready(lr_ready), .lr_addr(lr_addr), .lr_last(lr_last),
    .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_addr(lw_addr), .lw_last(lw_last),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .core_stall(core_stall)
  );

  int checks = 0, errors = 0;
  string ph = "R1 reset";
  bit done = 0;

  // list source
  logic [AW-1:0] src[0:31];
  int src_len = 0, src_last = -1, src_idx = 0;
  bit src_en = 0, wr_tog = 0, pf_tog = 0;

  // reference model state
  bit m_play, m_rec, m_paused, m_load, m_armed, m_rdone, m_wv, m_wl;
  int m_iss, m_rdcnt, m_reccnt;
  logic [AW-1:0] m_wa;
  logic [AW-1:0] m_win[$];
  bit s_play, s_rec, s_paused, s_load, s_armed, s_rdone;
  int s_iss, s_rdcnt, s_reccnt;
  logic [AW-1:0] s_win[$];

  function automatic bit e_rdy();
    return m_play && !m_paused && !m_rdone && m_win.size() < WIN;
  endfunction
  function automatic bit e_pfv();
    return m_play && m_armed && !m_paused && m_iss < int'(cfg_depth) && m_iss < m_win.size();
  endfunction

  task automatic chk(string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", ph, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("lr_ready", lr_ready, e_rdy());
    chk("pf_valid", pf_valid, e_pfv());
    if (e_pfv()) chk("pf_addr", pf_addr, m_win[m_iss]);
    chk("lw_valid", lw_valid, m_wv);
    if (m_wv) begin
      chk("lw_addr", lw_addr, m_wa);
      chk("lw_last", lw_last, m_wl);
    end
    chk("core_stall", core_stall, m_play && m_load);
  endtask

  task automatic model_step(output bit acc);
    bit v_play = m_play, v_rec = m_rec, v_paused = m_paused, v_load = m_load;
    bit v_armed = m_armed, v_rdone = m_rdone;
    int v_iss = m_iss, v_rdcnt = m_rdcnt, v_reccnt = m_reccnt;
    logic [AW-1:0] v_win[$] = m_win;
    bit rdy = e_rdy(), pfv = e_pfv(), took = 0;
    acc = 0;
    if (cmd_restore) begin
      m_play = s_play; m_rec = s_rec; m_paused = s_paused; m_load = s_load;
      m_armed = s_armed; m_rdone = s_rdone; m_iss = s_iss; m_rdcnt = s_rdcnt;
      m_reccnt = s_reccnt; m_win = s_win;
    end else if (cmd_start || cmd_stop) begin
      m_play = cmd_start && cmd_start_play;
      m_rec = cmd_start && cmd_start_rec;
      m_load = m_play; m_paused = 0; m_armed = 0; m_rdone = 0;
      m_iss = 0; m_rdcnt = 0; m_reccnt = 0; m_win = {};
    end else begin
      if (m_play && !m_paused) begin
        int iss = m_iss + ((pfv && pf_ready) ? 1 : 0);
        if (miss_valid) begin
          int k = -1;
          foreach (m_win[i]) if (k < 0 && m_win[i] == miss_addr) k = i;
          if (k >= 0) begin
            for (int n = 0; n <= k; n++) void'(m_win.pop_front());
            iss = (iss > k + 1) ? iss - k - 1 : 0;
            m_armed = 1;
          end
        end
        m_iss = iss;
        if (lr_valid && rdy) begin
          m_win.push_back(lr_addr);
          m_rdcnt++;
          acc = 1;
          if (lr_last || m_rdcnt >= int'(cfg_max_len)) m_rdone = 1;
        end
        if (m_load && (m_win.size() == WIN || m_rdone)) m_load = 0;
      end
      if (m_rec && !m_paused && miss_valid && miss_rec_ok && (!m_wv || lw_ready)) begin
        took = 1;
        m_wa = miss_addr;
        m_wl = (m_reccnt + 1 >= int'(cfg_max_len));
        m_reccnt++;
        if (m_wl) m_rec = 0;
      end
      if (cmd_pause) m_paused = 1;
      else if (cmd_resume) m_paused = 0;
    end
    if (took) m_wv = 1;
    else if (lw_ready) m_wv = 0;
    if (cmd_save) begin
      s_play = v_play; s_rec = v_rec; s_paused = v_paused; s_load = v_load;
      s_armed = v_armed; s_rdone = v_rdone; s_iss = v_iss; s_rdcnt = v_rdcnt;
      s_reccnt = v_reccnt; s_win = v_win;
    end
  endtask

  task automatic tick();
    bit acc;
    lr_valid = src_en && src_idx < src_len;
    lr_addr  = lr_valid ? src[src_idx] : '0;
    lr_last  = lr_valid && src_idx == src_last;
    lw_ready = wr_tog ? ~lw_ready : 1'b1;
    pf_ready = pf_tog ? ~pf_ready : 1'b1;
    model_step(acc);
    if (acc) src_idx++;
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic miss(logic [AW-1:0] a, logic ok);
    miss_valid = 1; miss_addr = a; miss_rec_ok = ok;
    tick();
    miss_valid = 0; miss_rec_ok = 0;
  endtask

  task automatic start(bit play, bit rec);
    cmd_start = 1; cmd_start_play = play; cmd_start_rec = rec;
    tick();
    cmd_start = 0; cmd_start_play = 0; cmd_start_rec = 0;
  endtask

  task automatic load_list(int len, int last, logic [AW-1:0] base);
    for (int i = 0; i < len; i++) src[i] = base + AW'(i);
    src_len = len; src_last = last; src_idx = 0; src_en = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog act 0 exp 1", ph);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_start = 0; cmd_start_play = 0; cmd_start_rec = 0; cmd_stop = 0;
    cmd_pause = 0; cmd_resume = 0; cmd_save = 0; cmd_restore = 0;
    cfg_depth = 3; cfg_max_len = 4; miss_valid = 0; miss_addr = '0; miss_rec_ok = 0;
    lr_valid = 0; lr_addr = '0; lr_last = 0; lw_ready = 1; pf_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: all outputs low straight after reset
    compare();

    // R2 R3 R4: record only, limit 4, stalling writer
    ph = "R2 R3 R4 record";
    start(0, 1);
    wr_tog = 1;
    for (int i = 0; i < 10; i++) miss(32'h200 + i, i != 2);
    ticks(3);
    wr_tog = 0;

    // R5 R6: playback load and stall
    ph = "R5 R6 playback load";
    cfg_max_len = 100; cfg_depth = 3;
    load_list(12, 11, 32'h100);
    start(1, 0);
    ticks(10);

    // R7 R8: matching with skip-ahead and prefetch
    ph = "R7 R8 match and prefetch";
    miss(32'h100, 0);
    ticks(3);
    pf_tog = 1;
    miss(32'h104, 0);
    ticks(2);
    miss(32'hdead, 0);
    miss(32'h103, 0);
    ticks(3);
    miss(32'h10b, 0);
    ticks(4);
    pf_tog = 0;

    // R9: playback and recording together
    ph = "R9 replay with record";
    cfg_max_len = 3;
    load_list(12, 11, 32'h100);
    start(1, 1);
    ticks(10);
    miss(32'h100, 1);
    miss(32'h102, 1);
    miss(32'h777, 1);
    miss(32'h105, 1);
    ticks(3);

    // R10: pause and resume
    ph = "R10 pause";
    cmd_pause = 1; cmd_resume = 1; tick(); cmd_pause = 0; cmd_resume = 0;
    miss(32'h106, 1);
    ticks(3);
    cmd_resume = 1; tick(); cmd_resume = 0;
    ticks(2);
    miss(32'h106, 1);

    // R11: save and restore
    ph = "R11 save restore";
    cmd_save = 1; tick(); cmd_save = 0;
    miss(32'h107, 0);
    miss(32'h109, 0);
    ticks(2);
    cmd_restore = 1; tick(); cmd_restore = 0;
    ticks(4);
    miss(32'h107, 0);
    ticks(2);

    // R12: command ranking
    ph = "R12 command priority";
    cfg_max_len = 50;
    load_list(12, 11, 32'h300);
    miss_valid = 1; miss_addr = 32'h108; miss_rec_ok = 1;
    cmd_stop = 1; start(1, 1); cmd_stop = 0;
    miss_valid = 0;
    ticks(9);
    miss(32'h301, 1);
    cmd_save = 1; tick(); cmd_save = 0;
    miss(32'h303, 1);
    cmd_restore = 1; start(1, 0); cmd_restore = 0;
    ticks(3);

    // R13: stop
    ph = "R13 stop";
    cmd_stop = 1; tick(); cmd_stop = 0;
    miss(32'h304, 1);
    ticks(3);

    // R6: read ended by the length limit
    ph = "R6 length limit";
    cfg_max_len = 6;
    load_list(20, -1, 32'h400);
    start(1, 0);
    ticks(12);
    miss(32'h400, 0);
    ticks(6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule